// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Controller

This block is the card-side configuration logic of a plug-and-play expansion card. The host first writes a register index to an address port, then writes or reads that register through a data port. A card-level state machine with four states controls which accesses take effect: waiting for the unlock key, sleeping, isolating and configuring. An external detector reports the unlock key as a one-cycle `key_seen` strobe.

The controller stores the card select number, the selected logical device and the read-port address. For each logical device it keeps an enable bit and a two-bit I/O range-check register. It walks a resource byte array, which arrives as a flat input vector, through a pointer and a ready flag. The three one-shot commands in the control register reset the devices, return the card to the key-wait state, or clear the select number.

While a device has range checking enabled and is not active, host reads of that device's I/O range return a fixed pattern byte on `io_data`, with `io_hit` asserted.

Top module: `pnp_card_ctrl`

## Requirements
- R1: After reset the card is in the key-wait state (`card_state` 0), the select number is 0, every device is inactive with range check off, `rd_port_addr` is 0 and the resource ready flag is low for one cycle.
- R2: A `key_seen` pulse moves the card from key-wait (0) to sleep (1) on the next clock. In any other state `key_seen` has no effect.
- R3: A write to index 0x03 whose data equals the select number moves a sleeping card to isolation (2) when the data is zero, or to config (3) when the data is nonzero, and resets the resource pointer to byte 0. A non-matching write to 0x03 moves a card in isolation or config back to sleep.
- R4: A write to index 0x02 acts per bit and the bits clear themselves. Bit 0 clears every device's enable and range-check bits and keeps the select number. Bit 1 returns the card to key-wait and keeps the select number. Bit 2 sets the select number to 0. A read of 0x02 returns 0x00.
- R5: Register reads, and register writes other than index 0x03, take effect only in config. Outside config a read returns 0x00. The one exception is the select-number write of R7, which isolation also accepts.
- R6: A write to index 0x00 sets `rd_port_addr[9:2]` to the data, with `rd_port_addr[1:0]` at 0. A read of 0x00 returns 0x00.
- R7: Index 0x06 reads and writes the select number. A write of it in isolation also moves the card to config.
- R8: Index 0x07 reads and writes the selected device number, and a value at or above `NUM_LDN` is ignored. With `NUM_LDN` = 1 the index reads 0x00.
- R9: Index 0x30 bit 0 sets the selected device's enable bit, which shows on `dev_active`. Bits 7:1 read as 0.
- R10: Index 0x31 stores bits 1:0 for the selected device: bit 1 enables the range check and bit 0 chooses the reply. Bits 7:2 read as 0.
- R11: When `io_rd` addresses a device whose range check is enabled and which is inactive, `io_hit` is 1 and `io_data` is 0x55 if its reply bit is set, or 0xAA if it is clear. Otherwise `io_hit` is 0 and `io_data` is 0x00.
- R12: A ready read of index 0x04 returns resource byte p, taken from `rom_bytes[8p+7:8p]`, and advances p. Once p reaches `ROM_DEPTH` the read returns 0x00. A read while not ready returns 0x00 and does not advance p.
- R13: Index 0x05 bit 0 is the ready flag. It clears in the cycle after a byte is consumed or the pointer is reset, and it sets again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_seen | input | 1 | One-cycle strobe: the unlock key was detected |
| addr_wr | input | 1 | Write strobe for the index (address) port |
| addr_wdata | input | 8 | Register index |
| data_wr | input | 1 | Write strobe for the data port |
| data_wdata | input | 8 | Data written to the indexed register |
| data_rd | input | 1 | Read strobe for the read port |
| rd_data | output | 8 | Read data of the indexed register (combinational) |
| rom_bytes | input | 8*ROM_DEPTH | Resource byte array; byte k is at bits 8k+7:8k |
| io_rd | input | 1 | Host read of a device's assigned I/O range |
| io_ldn | input | LDN_W | Device whose range the host read hits |
| io_hit | output | 1 | The card drives a range-check reply |
| io_data | output | 8 | Range-check reply byte |
| rd_port_addr | output | 10 | Programmed read-port address |
| card_state | output | 2 | 0 key-wait, 1 sleep, 2 isolation, 3 config |
| csn | output | 8 | Card select number |
| dev_active | output | NUM_LDN | Per-device enable bits |

## Verification
The bench builds two instances. The first has `NUM_LDN` = 2 and `ROM_DEPTH` = 6, so a handful of reads run the pointer past the array end, and the second device checks that each device's registers are kept apart. The second instance has `NUM_LDN` = 1 and is driven with the same stimulus. It covers the single-device case, where the device-select index reads as zero and out-of-range selections are dropped.

// File: rtl/pnp_card_pkg.sv
// Shared types and register indices for the plug-and-play card controller.
// Assumes an 8-bit index space; indices listed here are decoded by the top.
package pnp_card_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_KEY = 2'd0,
        ST_SLEEP    = 2'd1,
        ST_ISOLATE  = 2'd2,
        ST_CONFIG   = 2'd3
    } card_state_e;

    localparam logic [7:0] IDX_RDPORT = 8'h00;
    localparam logic [7:0] IDX_CTRL   = 8'h02;
    localparam logic [7:0] IDX_WAKE   = 8'h03;
    localparam logic [7:0] IDX_RES    = 8'h04;
    localparam logic [7:0] IDX_STAT   = 8'h05;
    localparam logic [7:0] IDX_CSN    = 8'h06;
    localparam logic [7:0] IDX_LDN    = 8'h07;
    localparam logic [7:0] IDX_ACT    = 8'h30;
    localparam logic [7:0] IDX_RCHK   = 8'h31;

    localparam logic [7:0] RCHK_ONE  = 8'h55;
    localparam logic [7:0] RCHK_ZERO = 8'hAA;

endpackage

// File: rtl/pnp_card_fsm.sv
// Card-level state machine and card select number.
// Assumes the top has already gated writes by state: csn_wr only in
// isolation/config, cmd_* only in config. wake_wr is ungated.
module pnp_card_fsm
    import pnp_card_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_seen,
    input  logic        wake_wr,
    input  logic        csn_wr,
    input  logic [7:0]  wdata,
    input  logic        cmd_wfk,
    input  logic        cmd_csn_clr,
    output card_state_e state,
    output logic [7:0]  csn,
    output logic        ptr_rst
);

    logic wake_match;

    assign wake_match = (wdata == csn);
    assign ptr_rst    = wake_wr && (state != ST_WAIT_KEY) && wake_match;

    // State transitions: key, return command, wake and CSN assignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT_KEY;
        end else if (state == ST_WAIT_KEY) begin
            if (key_seen) state <= ST_SLEEP;
        end else if (cmd_wfk) begin
            state <= ST_WAIT_KEY;
        end else if (wake_wr) begin
            if (wake_match && state == ST_SLEEP)
                state <= (wdata == 8'h00) ? ST_ISOLATE : ST_CONFIG;
            else if (!wake_match && state != ST_SLEEP)
                state <= ST_SLEEP;
        end else if (csn_wr && state == ST_ISOLATE) begin
            state <= ST_CONFIG;
        end
    end

    // Card select number: cleared by command, loaded by a CSN write.
    always_ff @(posedge clk) begin
        if (!rst_n)           csn <= 8'h00;
        else if (cmd_csn_clr) csn <= 8'h00;
        else if (csn_wr)      csn <= wdata;
    end

    p_key_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_KEY && key_seen) |=> state == ST_SLEEP);

    p_wake_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && wake_wr && wdata == csn && wdata != 8'h00)
        |=> state == ST_CONFIG);

    p_wake_iso_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && wake_wr && wdata == csn && wdata == 8'h00)
        |=> state == ST_ISOLATE);

    p_cmd_wfk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wfk && !cmd_csn_clr) |=> (state == ST_WAIT_KEY && csn == $past(csn)));

    p_csn_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_csn_clr |=> csn == 8'h00);

endmodule

// File: rtl/pnp_res_ptr.sv
// Resource byte pointer with a ready flag.
// A consume is a ready read; it returns the pointed byte (0 past the end),
// advances the pointer and drops ready for one cycle.
module pnp_res_ptr #(
    parameter int ROM_DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ptr_rst,
    input  logic                   rd_req,
    input  logic [ROM_DEPTH*8-1:0] rom_bytes,
    output logic [7:0]             res_byte,
    output logic                   ready
);

    localparam int PTR_W = $clog2(ROM_DEPTH + 1);

    logic [PTR_W-1:0] ptr;
    logic             in_range;
    logic             consume;

    assign in_range = (int'(ptr) < ROM_DEPTH);
    assign consume  = rd_req && ready;

    // Byte selection: zero when not ready or past the end.
    always_comb begin
        res_byte = 8'h00;
        if (ready && in_range) res_byte = rom_bytes[8*int'(ptr) +: 8];
    end

    // Pointer: reset by wake, advanced by consume, saturates at the end.
    always_ff @(posedge clk) begin
        if (!rst_n || ptr_rst)        ptr <= '0;
        else if (consume && in_range) ptr <= ptr + 1'b1;
    end

    // Ready flag: low for one cycle after a consume or a pointer reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ready <= 1'b0;
        else if (ptr_rst || consume) ready <= 1'b0;
        else                         ready <= 1'b1;
    end

    p_consume_clr_r13: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> !ready);

    p_ready_set_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !ptr_rst) |=> ready);

    p_ptr_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) <= ROM_DEPTH);

endmodule

// File: rtl/pnp_ldev_regs.sv
// Per-logical-device enable and range-check registers, plus the
// range-check reply. Assumes act_wr/rchk_wr/dev_reset are config-gated.
module pnp_ldev_regs #(
    parameter int NUM_LDN = 2,
    localparam int LDN_W  = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LDN_W-1:0]   sel,
    input  logic               act_wr,
    input  logic               rchk_wr,
    input  logic [7:0]         wdata,
    input  logic               dev_reset,
    input  logic               io_rd,
    input  logic [LDN_W-1:0]   io_ldn,
    output logic               sel_act,
    output logic [1:0]         sel_rchk,
    output logic [NUM_LDN-1:0] dev_active,
    output logic               io_hit,
    output logic [7:0]         io_data
);

    logic [1:0] rchk [NUM_LDN];
    logic       sel_ok;
    logic       io_ok;

    assign sel_ok = (int'(sel) < NUM_LDN);
    assign io_ok  = (int'(io_ldn) < NUM_LDN);

    for (genvar g = 0; g < NUM_LDN; g++) begin : g_dev
        // Device g registers: cleared by reset command, written when selected.
        always_ff @(posedge clk) begin
            if (!rst_n || dev_reset) begin
                dev_active[g] <= 1'b0;
                rchk[g]       <= 2'b00;
            end else begin
                if (act_wr && sel == LDN_W'(g))  dev_active[g] <= wdata[0];
                if (rchk_wr && sel == LDN_W'(g)) rchk[g]       <= wdata[1:0];
            end
        end
    end

    // Readback of the selected device.
    always_comb begin
        sel_act  = 1'b0;
        sel_rchk = 2'b00;
        if (sel_ok) begin
            sel_act  = dev_active[sel];
            sel_rchk = rchk[sel];
        end
    end

    // Range-check reply for the addressed device.
    always_comb begin
        io_hit  = 1'b0;
        io_data = 8'h00;
        if (io_rd && io_ok && rchk[io_ldn][1] && !dev_active[io_ldn]) begin
            io_hit  = 1'b1;
            io_data = rchk[io_ldn][0] ? pnp_card_pkg::RCHK_ONE : pnp_card_pkg::RCHK_ZERO;
        end
    end

    p_dev_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |=> dev_active == '0);

    p_act_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_wr && sel_ok) |=> dev_active[$past(sel)] == $past(wdata[0]));

    p_io_pattern_r11: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> (io_data == 8'h55 || io_data == 8'hAA));

endmodule

// File: rtl/pnp_card_ctrl.sv
// Top of the plug-and-play card controller: index register, write/read
// decode, read-port address and device select. Assumes one host access
// strobe per cycle; rd_data is valid combinationally while data_rd is high.
module pnp_card_ctrl
    import pnp_card_pkg::*;
#(
    parameter int  NUM_LDN   = 2,
    parameter int  ROM_DEPTH = 16,
    localparam int LDN_W     = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   key_seen,
    input  logic                   addr_wr,
    input  logic [7:0]             addr_wdata,
    input  logic                   data_wr,
    input  logic [7:0]             data_wdata,
    input  logic                   data_rd,
    output logic [7:0]             rd_data,
    input  logic [ROM_DEPTH*8-1:0] rom_bytes,
    input  logic                   io_rd,
    input  logic [LDN_W-1:0]       io_ldn,
    output logic                   io_hit,
    output logic [7:0]             io_data,
    output logic [9:0]             rd_port_addr,
    output logic [1:0]             card_state,
    output logic [7:0]             csn,
    output logic [NUM_LDN-1:0]     dev_active
);

    card_state_e      state;
    logic [7:0]       idx;
    logic [7:0]       rdport;
    logic [LDN_W-1:0] ldn;
    logic             in_cfg;
    logic             cfg_wr;
    logic             cfg_rd;
    logic             ctrl_wr;
    logic             csn_wr;
    logic             ptr_rst;
    logic             sel_act;
    logic [1:0]       sel_rchk;
    logic [7:0]       res_byte;
    logic             ready;

    assign in_cfg       = (state == ST_CONFIG);
    assign cfg_wr       = data_wr && in_cfg;
    assign cfg_rd       = data_rd && in_cfg;
    assign ctrl_wr      = cfg_wr && idx == IDX_CTRL;
    assign csn_wr       = data_wr && idx == IDX_CSN && (in_cfg || state == ST_ISOLATE);
    assign card_state   = state;
    assign rd_port_addr = {rdport, 2'b00};

    // Index register: loaded by every address-port write.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= 8'h00;
        else if (addr_wr) idx <= addr_wdata;
    end

    // Read-port address bits 9:2.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rdport <= 8'h00;
        else if (cfg_wr && idx == IDX_RDPORT) rdport <= data_wdata;
    end

    if (NUM_LDN > 1) begin : g_multi_ldn
        // Device select: values beyond the device count are dropped.
        always_ff @(posedge clk) begin
            if (!rst_n) ldn <= '0;
            else if (cfg_wr && idx == IDX_LDN && int'(data_wdata) < NUM_LDN)
                ldn <= data_wdata[LDN_W-1:0];
        end
    end else begin : g_single_ldn
        assign ldn = '0;
    end

    pnp_card_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_seen    (key_seen),
        .wake_wr     (data_wr && idx == IDX_WAKE),
        .csn_wr      (csn_wr),
        .wdata       (data_wdata),
        .cmd_wfk     (ctrl_wr && data_wdata[1]),
        .cmd_csn_clr (ctrl_wr && data_wdata[2]),
        .state       (state),
        .csn         (csn),
        .ptr_rst     (ptr_rst)
    );

    pnp_res_ptr #(.ROM_DEPTH(ROM_DEPTH)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_rst   (ptr_rst),
        .rd_req    (cfg_rd && idx == IDX_RES),
        .rom_bytes (rom_bytes),
        .res_byte  (res_byte),
        .ready     (ready)
    );

    pnp_ldev_regs #(.NUM_LDN(NUM_LDN)) u_ldev (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (ldn),
        .act_wr     (cfg_wr && idx == IDX_ACT),
        .rchk_wr    (cfg_wr && idx == IDX_RCHK),
        .wdata      (data_wdata),
        .dev_reset  (ctrl_wr && data_wdata[0]),
        .io_rd      (io_rd),
        .io_ldn     (io_ldn),
        .sel_act    (sel_act),
        .sel_rchk   (sel_rchk),
        .dev_active (dev_active),
        .io_hit     (io_hit),
        .io_data    (io_data)
    );

    // Read mux: zero outside config and for write-only indices.
    always_comb begin
        rd_data = 8'h00;
        if (cfg_rd) begin
            case (idx)
                IDX_RES:  rd_data = res_byte;
                IDX_STAT: rd_data = {7'b0, ready};
                IDX_CSN:  rd_data = csn;
                IDX_LDN:  rd_data = 8'(ldn);
                IDX_ACT:  rd_data = {7'b0, sel_act};
                IDX_RCHK: rd_data = {6'b0, sel_rchk};
                default:  rd_data = 8'h00;
            endcase
        end
    end

    p_rd_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && state != ST_CONFIG) |-> rd_data == 8'h00);

    p_rdport_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && idx == IDX_RDPORT) |=> rd_port_addr[9:2] == $past(data_wdata));

    p_csn_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_wr) |=> csn == $past(csn));

endmodule

// File: tb/sim_pnp_card_ctrl.sv
module sim_pnp_card_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             key_seen = 1'b0;
    logic             addr_wr = 1'b0;
    logic [7:0]       addr_wdata = 8'h00;
    logic             data_wr = 1'b0;
    logic [7:0]       data_wdata = 8'h00;
    logic             data_rd = 1'b0;
    logic [DEPTH*8-1:0] rom_bytes;
    logic             io_rd = 1'b0;
    logic [0:0]       io_ldn = 1'b0;
    logic [7:0]       rd_data, rd_data1, io_data, io_data1, csn, csn1;
    logic             io_hit, io_hit1;
    logic [9:0]       rd_port_addr, rd_port_addr1;
    logic [1:0]       card_state, card_state1;
    logic [1:0]       dev_active;
    logic [0:0]       dev_active1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pnp_card_ctrl #(.NUM_LDN(2), .ROM_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .key_seen(key_seen),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .data_wr(data_wr), .data_wdata(data_wdata), .data_rd(data_rd),
        .rd_data(rd_data), .rom_bytes(rom_bytes),
        .io_rd(io_rd), .io_ldn(io_ldn), .io_hit(io_hit), .io_data(io_data),
        .rd_port_addr(rd_port_addr), .card_state(card_state), .csn(csn),
        .dev_active(dev_active)
    );

    pnp_card_ctrl #(.NUM_LDN(1), .ROM_DEPTH(DEPTH)) u1 (
        .clk(clk), .rst_n(rst_n), .key_seen(key_seen),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .data_wr(data_wr), .data_wdata(data_wdata), .data_rd(data_rd),
        .rd_data(rd_data1), .rom_bytes(rom_bytes),
        .io_rd(io_rd), .io_ldn(io_ldn), .io_hit(io_hit1), .io_data(io_data1),
        .rd_port_addr(rd_port_addr1), .card_state(card_state1), .csn(csn1),
        .dev_active(dev_active1)
    );

    function automatic logic [7:0] rom_val(int k);
        return 8'h3C ^ 8'(k * 37);
    endfunction

    function automatic logic [7:0] io_exp(logic [1:0] rc, logic act);
        if (rc[1] && !act) return rc[0] ? 8'h55 : 8'hAA;
        return 8'h00;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic set_idx(logic [7:0] i);
        addr_wr = 1'b1; addr_wdata = i;
        @(negedge clk); addr_wr = 1'b0;
    endtask

    task automatic wr(logic [7:0] i, logic [7:0] d);
        set_idx(i);
        data_wr = 1'b1; data_wdata = d;
        @(negedge clk); data_wr = 1'b0;
        #1;
    endtask

    task automatic rd_cur(output logic [7:0] v, output logic [7:0] v1);
        data_rd = 1'b1;
        #1; v = rd_data; v1 = rd_data1;
        @(negedge clk); data_rd = 1'b0;
        #1;
    endtask

    task automatic rd(logic [7:0] i, output logic [7:0] v, output logic [7:0] v1);
        set_idx(i);
        rd_cur(v, v1);
    endtask

    task automatic pulse_key();
        key_seen = 1'b1;
        @(negedge clk); key_seen = 1'b0;
        #1;
    endtask

    task automatic probe(logic d, logic [1:0] rc, logic act, string req);
        io_ldn = d; io_rd = 1'b1;
        #1;
        chk(req, {7'b0, io_hit, io_data}, {7'b0, rc[1] && !act, io_exp(rc, act)});
        io_rd = 1'b0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v1;
        logic [1:0] m_rc [2];
        logic       m_act [2];
        void'($urandom(32'd4021));
        for (int k = 0; k < DEPTH; k++) rom_bytes[8*k +: 8] = rom_val(k);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        chk("R1 state", 16'(card_state), 16'd0);
        chk("R1 csn", 16'(csn), 16'd0);
        chk("R1 rdport", 16'(rd_port_addr), 16'd0);
        chk("R1 active", 16'(dev_active), 16'd0);
        probe(1'b0, 2'b00, 1'b0, "R1 io");

        // R5: writes and reads in key-wait have no effect
        wr(8'h06, 8'h12);
        chk("R5 csn in key-wait", 16'(csn), 16'd0);
        rd(8'h06, v, v1);
        chk("R5 read in key-wait", 16'(v), 16'd0);
        wr(8'h03, 8'h00);
        chk("R5 wake in key-wait", 16'(card_state), 16'd0);

        // R2 key moves to sleep; a second key in sleep does nothing
        pulse_key();
        chk("R2 key to sleep", 16'(card_state), 16'd1);
        pulse_key();
        chk("R2 key in sleep", 16'(card_state), 16'd1);

        // R3 zero wake to isolation, R7 CSN assignment moves to config
        wr(8'h03, 8'h00);
        chk("R3 wake zero", 16'(card_state), 16'd2);
        wr(8'h06, 8'h5A);
        chk("R7 csn in isolation", 16'(csn), 16'h5A);
        chk("R7 isolation to config", 16'(card_state), 16'd3);
        rd(8'h06, v, v1);
        chk("R7 csn read", 16'(v), 16'h5A);

        // R3 mismatching wake to sleep, then matching wake to config
        wr(8'h03, 8'h33);
        chk("R3 mismatch to sleep", 16'(card_state), 16'd1);
        wr(8'h06, 8'h77);
        chk("R5 csn write in sleep", 16'(csn), 16'h5A);
        wr(8'h03, 8'h5A);
        chk("R3 match to config", 16'(card_state), 16'd3);

        // R6 read-port address
        wr(8'h00, 8'hC3);
        chk("R6 rdport", 16'(rd_port_addr), 16'h30C);
        rd(8'h00, v, v1);
        chk("R6 read ignored", 16'(v), 16'd0);

        // R13 status ready, R12 resource bytes
        rd(8'h05, v, v1);
        chk("R13 ready set", 16'(v), 16'd1);
        set_idx(8'h04);
        rd_cur(v, v1);
        chk("R12 byte 0", 16'(v), 16'(rom_val(0)));
        rd_cur(v, v1);
        chk("R13 not ready after consume", 16'(v), 16'd0);
        rd_cur(v, v1);
        chk("R12 no advance when not ready", 16'(v), 16'(rom_val(1)));
        for (int k = 2; k < DEPTH + 2; k++) begin
            @(negedge clk); #1;
            rd_cur(v, v1);
            chk("R12 sequential byte", 16'(v), (k < DEPTH) ? 16'(rom_val(k)) : 16'd0);
        end
        rd(8'h05, v, v1);
        chk("R13 ready after idle", 16'(v), 16'd1);

        // R3 pointer reset by matching wake
        wr(8'h03, 8'h01);
        wr(8'h03, 8'h5A);
        rd(8'h04, v, v1);
        chk("R3 pointer reset", 16'(v), 16'(rom_val(0)));

        // R8 device select
        wr(8'h07, 8'h01);
        rd(8'h07, v, v1);
        chk("R8 ldn read", 16'(v), 16'd1);
        chk("R8 single device reads zero", 16'(v1), 16'd0);
        wr(8'h07, 8'h02);
        rd(8'h07, v, v1);
        chk("R8 out of range ignored", 16'(v), 16'd1);

        // R9/R10/R11 random device programming checked against a model
        m_act[0] = 1'b0; m_act[1] = 1'b0; m_rc[0] = 2'b00; m_rc[1] = 2'b00;
        for (int it = 0; it < 40; it++) begin
            int d;
            logic [7:0] a, r;
            d = int'($urandom_range(1, 0));
            a = 8'($urandom);
            r = 8'($urandom);
            wr(8'h07, 8'(d));
            wr(8'h30, a);
            wr(8'h31, r);
            m_act[d] = a[0];
            m_rc[d]  = r[1:0];
            rd(8'h30, v, v1);
            chk("R9 activate read", 16'(v), 16'({7'b0, m_act[d]}));
            rd(8'h31, v, v1);
            chk("R10 range-check read", 16'(v), 16'({6'b0, m_rc[d]}));
            chk("R9 dev_active", 16'(dev_active), 16'({m_act[1], m_act[0]}));
            probe(1'b0, m_rc[0], m_act[0], "R11 io dev0");
            probe(1'b1, m_rc[1], m_act[1], "R11 io dev1");
        end

        // R11 directed corners: both patterns, and activation suppresses
        wr(8'h07, 8'h00); wr(8'h30, 8'h00); wr(8'h31, 8'h03);
        wr(8'h07, 8'h01); wr(8'h30, 8'h00); wr(8'h31, 8'h02);
        probe(1'b0, 2'b11, 1'b0, "R11 pattern 55");
        probe(1'b1, 2'b10, 1'b0, "R11 pattern AA");
        wr(8'h30, 8'hFF);
        probe(1'b1, 2'b10, 1'b1, "R11 active suppresses");

        // R4 control commands
        wr(8'h02, 8'h01);
        chk("R4 device reset", 16'(dev_active), 16'd0);
        chk("R4 device reset keeps csn", 16'(csn), 16'h5A);
        probe(1'b0, 2'b00, 1'b0, "R4 range check cleared");
        rd(8'h02, v, v1);
        chk("R4 ctrl reads zero", 16'(v), 16'd0);
        wr(8'h02, 8'h04);
        chk("R4 csn clear", 16'(csn), 16'd0);
        chk("R4 csn clear keeps state", 16'(card_state), 16'd3);
        wr(8'h06, 8'h21);
        wr(8'h02, 8'h02);
        chk("R4 return to key-wait", 16'(card_state), 16'd0);
        chk("R4 key-wait keeps csn", 16'(csn), 16'h21);
        chk("R4 single device state", 16'(card_state1), 16'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule